// File: doc/BRIEF.md
# Credit-Gated Partitioned Receive Buffer

This block is the receive side of a many-to-one link where several senders share one input buffer without risk of overflow. The buffer is split into equal slices, one per sender, and each sender is paired with a credit counter that starts equal to its slice depth. A send request is granted only while that sender still holds a credit, so one sender's burst can never take space that belongs to another, and the buffer can never be written past its capacity.

A single consumer drains the buffer one word per cycle. It visits the non-empty slices in rotating order. Each drained word produces a one-cycle credit pulse on a return line for its source. The source's counter takes that credit back one cycle after the pulse. Messages are single fixed-width words. Their contents are not interpreted.

Top module: `credit_rx_buffer`

## Requirements
- R1: After reset, every source's credit reads SLICE_DEPTH (4), `pop_valid_o` is 0 and `credit_ret_o` is all zero.
- R2: `send_gnt_o[s]` is 1 exactly when `send_req_i[s]` is 1 and the credit of source s is non-zero. A granted word is stored in slice s at that clock edge.
- R3: A grant without a return in the same cycle lowers the credit of s by one. No slice is ever written while full.
- R4: A pop of a word from slice s raises `credit_ret_o[s]` for exactly the next cycle. No other bit of `credit_ret_o` rises for that pop.
- R5: If a grant and a credit-return pulse occur for the same source in the same cycle, that source's credit stays unchanged.
- R6: A credit-return pulse with no grant raises that source's credit by one at the following edge.
- R7: The words of one source leave in the order they were granted. `pop_data_o` shows the head word of the selected slice.
- R8: The consumer picks the first non-empty slice after the last served source, in ascending index order with wrap-around. After reset the search starts at source 0.
- R9: `pop_valid_o` is 1 exactly when some slice is non-empty. A `pop_i` while `pop_valid_o` is 0 has no effect: it produces no return pulse and no change of state.
- R10: `pop_src_o` gives the index of the source whose word is on `pop_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| send_req_i | input | N | Per-source send request |
| send_data_i | input | N*DATA_W | Per-source word; source s occupies bits [s*DATA_W +: DATA_W] |
| send_gnt_o | output | N | Per-source grant; the word is stored when high |
| credit_o | output | N*CW | Per-source credit count; source s occupies [s*CW +: CW] |
| pop_i | input | 1 | Consumer takes the presented word |
| pop_valid_o | output | 1 | A word is presented |
| pop_data_o | output | DATA_W | Presented word |
| pop_src_o | output | SRC_W | Source of the presented word |
| credit_ret_o | output | N | One-cycle credit-return pulse per source |

## Verification
The bench runs phases of different request and pop densities, including saturation with no pops. In that phase a source whose credit stayed above zero at exhaustion would write into a full slice and overwrite a stored word. It also covers full drains and simultaneous send and drain. In those cases a counter that both decrements and increments in one cycle would drift, and credits would leak or multiply. The rotating pointer is checked against a model at every pop. A fixed-priority picker would starve high-index sources, and a pointer that moves on an idle `pop_i` would skip a source. Both show up as a wrong `pop_src_o`.

// File: rtl/crb_pkg.sv
package crb_pkg;
  function automatic int unsigned cnt_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/crb_credit_tracker.sv
module crb_credit_tracker #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          ret_i,
  output logic          gnt_o,
  output logic [CW-1:0] credit_o
);
  logic [CW-1:0] credit_q;

  assign gnt_o    = req_i && (credit_q != '0);
  assign credit_o = credit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      credit_q <= CW'(DEPTH);
    end else begin
      unique case ({gnt_o, ret_i})
        2'b10:   credit_q <= credit_q - 1'b1;
        2'b01:   credit_q <= credit_q + 1'b1;
        default: credit_q <= credit_q;
      endcase
    end
  end
endmodule

// File: rtl/crb_slice.sv
module crb_slice #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned CW     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [CW-1:0]     count_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [CW-1:0]     count_q;

  assign empty_o   = (count_q == '0);
  assign full_o    = (count_q == CW'(DEPTH));
  assign count_o   = count_q;
  assign rd_data_o = mem_q[rptr_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (wr_i) wptr_q <= bump(wptr_q);
      if (rd_i) rptr_q <= bump(rptr_q);
      unique case ({wr_i, rd_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wptr_q] <= wr_data_i;
  end
endmodule

// File: rtl/crb_rr_pick.sv
module crb_rr_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] last_q;
  logic          found;
  int unsigned   cand;

  always_comb begin
    found = 1'b0;
    idx_o = '0;
    cand  = 0;
    for (int unsigned k = 1; k <= N; k++) begin
      cand = (int'(last_q) + k) % N;
      if (!found && req_i[cand]) begin
        found = 1'b1;
        idx_o = IW'(cand);
      end
    end
  end

  assign valid_o = found;

  // search after reset begins at index 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                last_q <= IW'(N - 1);
    else if (adv_i && valid_o)  last_q <= idx_o;
  end
endmodule

// File: rtl/credit_rx_buffer.sv
module credit_rx_buffer
  import crb_pkg::*;
#(
  parameter int unsigned SRC_W       = 2,
  parameter int unsigned SLICE_DEPTH = 4,
  parameter int unsigned DATA_W      = 16,
  localparam int unsigned N          = 1 << SRC_W,
  localparam int unsigned CW         = cnt_bits(SLICE_DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        send_req_i,
  input  logic [N*DATA_W-1:0] send_data_i,
  output logic [N-1:0]        send_gnt_o,
  output logic [N*CW-1:0]     credit_o,
  input  logic                pop_i,
  output logic                pop_valid_o,
  output logic [DATA_W-1:0]   pop_data_o,
  output logic [SRC_W-1:0]    pop_src_o,
  output logic [N-1:0]        credit_ret_o
);
  logic [DATA_W-1:0] rd_data [N];
  logic [N-1:0]      slice_empty, slice_full, slice_rd;
  logic [N*CW-1:0]   count_flat;
  logic [N-1:0]      ret_q;
  logic              pop_fire;

  assign pop_fire = pop_i && pop_valid_o;

  for (genvar s = 0; s < N; s++) begin : g_src
    crb_credit_tracker #(.DEPTH(SLICE_DEPTH), .CW(CW)) u_trk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (send_req_i[s]),
      .ret_i    (ret_q[s]),
      .gnt_o    (send_gnt_o[s]),
      .credit_o (credit_o[s*CW +: CW])
    );

    assign slice_rd[s] = pop_fire && (pop_src_o == SRC_W'(s));

    crb_slice #(.DATA_W(DATA_W), .DEPTH(SLICE_DEPTH), .CW(CW)) u_slc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (send_gnt_o[s]),
      .wr_data_i (send_data_i[s*DATA_W +: DATA_W]),
      .rd_i      (slice_rd[s]),
      .rd_data_o (rd_data[s]),
      .empty_o   (slice_empty[s]),
      .full_o    (slice_full[s]),
      .count_o   (count_flat[s*CW +: CW])
    );
  end

  crb_rr_pick #(.N(N), .IW(SRC_W)) u_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (~slice_empty),
    .adv_i   (pop_i),
    .valid_o (pop_valid_o),
    .idx_o   (pop_src_o)
  );

  assign pop_data_o = rd_data[pop_src_o];

  // credit-return channel: one registered pulse per drained word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ret_q <= '0;
    else         ret_q <= slice_rd;
  end

  assign credit_ret_o = ret_q;
endmodule

// File: rtl/crb_checker.sv
module crb_checker #(
  parameter int unsigned N     = 4,
  parameter int unsigned IW    = 2,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CW    = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  gnt,
  input logic [N-1:0]  full,
  input logic [N*CW-1:0] credit,
  input logic [N*CW-1:0] count,
  input logic [N-1:0]  ret,
  input logic          pop,
  input logic          pop_valid,
  input logic [IW-1:0] pop_src
);
  p_ret_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ret));

  p_idle_pop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_valid |=> (ret == '0));

  for (genvar s = 0; s < N; s++) begin : g_chk
    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(gnt[s] && full[s]));

    p_credit_sum_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (32'(credit[s*CW +: CW]) + 32'(count[s*CW +: CW]) + 32'(ret[s])) == 32'(DEPTH));

    p_ret_after_pop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop && pop_valid && pop_src == IW'(s)) |=> ret[s]);

    p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt[s] && ret[s]) |=> $stable(credit[s*CW +: CW]));
  end
endmodule

bind credit_rx_buffer crb_checker #(
  .N(N), .IW(SRC_W), .DEPTH(SLICE_DEPTH), .CW(CW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .gnt       (send_gnt_o),
  .full      (slice_full),
  .credit    (credit_o),
  .count     (count_flat),
  .ret       (credit_ret_o),
  .pop       (pop_i),
  .pop_valid (pop_valid_o),
  .pop_src   (pop_src_o)
);

// File: tb/tb_credit_rx_buffer.sv
`timescale 1ns/1ps
module tb_credit_rx_buffer;
  localparam int SW = 2;
  localparam int N  = 4;
  localparam int D  = 4;
  localparam int DW = 16;
  localparam int CW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req = '0;
  logic [N*DW-1:0] data = '0;
  logic [N-1:0]    gnt;
  logic [N*CW-1:0] credit;
  logic            pop = 1'b0;
  logic            pop_valid;
  logic [DW-1:0]   pop_data;
  logic [SW-1:0]   pop_src;
  logic [N-1:0]    ret;

  always #2 clk = ~clk;

  credit_rx_buffer #(.SRC_W(SW), .SLICE_DEPTH(D), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .send_req_i(req), .send_data_i(data),
    .send_gnt_o(gnt), .credit_o(credit), .pop_i(pop), .pop_valid_o(pop_valid),
    .pop_data_o(pop_data), .pop_src_o(pop_src), .credit_ret_o(ret));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int          m_cred [N];
  int          m_cnt  [N];
  int          m_rp   [N];
  bit          m_pend [N];
  logic [DW-1:0] m_q  [N][D];
  int          m_last;
  int          cyc = 0;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  function automatic int pick();
    for (int k = 1; k <= N; k++) begin
      int c = (m_last + k) % N;
      if (m_cnt[c] != 0) return c;
    end
    return -1;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < N; s++) begin
      m_cred[s] = D; m_cnt[s] = 0; m_rp[s] = 0; m_pend[s] = 0;
    end
    m_last = N - 1;
  endtask

  // drive at negedge, compare after settle, advance model at posedge
  task automatic step(input int req_pct, input int pop_pct);
    int  p;
    bit  sent [N];
    @(negedge clk);
    cyc++;
    for (int s = 0; s < N; s++) begin
      req[s] = ($urandom % 100) < req_pct;
      data[s*DW +: DW] = DW'(cyc * N + s);
    end
    pop = ($urandom % 100) < pop_pct;
    #0.5;
    p = pick();
    for (int s = 0; s < N; s++) begin
      chk("R2 grant", 32'(gnt[s]), 32'(req[s] && m_cred[s] > 0));
      chk("R3 R5 R6 credit", 32'(credit[s*CW +: CW]), 32'(m_cred[s]));
      chk("R4 return", 32'(ret[s]), 32'(m_pend[s]));
    end
    chk("R9 valid", 32'(pop_valid), 32'(p >= 0));
    if (p >= 0) begin
      chk("R8 R10 source", 32'(pop_src), 32'(p));
      chk("R7 data", 32'(pop_data), 32'(m_q[p][m_rp[p]]));
    end
    @(posedge clk);
    for (int s = 0; s < N; s++) begin
      sent[s] = req[s] && m_cred[s] > 0;
      m_cred[s] = m_cred[s] - int'(sent[s]) + int'(m_pend[s]);
      m_pend[s] = 0;
      if (sent[s]) begin
        m_q[s][(m_rp[s] + m_cnt[s]) % D] = data[s*DW +: DW];
        m_cnt[s]++;
      end
    end
    if (pop && p >= 0) begin
      m_rp[p] = (m_rp[p] + 1) % D;
      m_cnt[p]--;
      m_pend[p] = 1;
      m_last = p;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #0.5;
    // R1 reset state
    for (int s = 0; s < N; s++)
      chk("R1 reset credit", 32'(credit[s*CW +: CW]), 32'(D));
    chk("R1 reset valid", 32'(pop_valid), 32'd0);
    chk("R1 reset return", 32'(ret), 32'd0);

    repeat (10)  step(0, 100);   // R9: pop with nothing stored
    repeat (12)  step(100, 0);   // saturate all slices, credits to zero
    repeat (24)  step(0, 100);   // full drain, rotating order
    repeat (12)  step(100, 100); // send and return together
    repeat (600) step(50, 50);
    repeat (600) step(90, 30);
    repeat (600) step(20, 90);
    repeat (600) step(100, 100);
    repeat (20)  step(0, 0);
    repeat (30)  step(0, 100);
    repeat (10)  step(0, 100);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule